// File: doc/BRIEF.md
# Write Completion Status Read Path

This block is the read-data selector of a byte-wide nonvolatile memory that has to report programming progress on its own data bus. While the array is idle, a read cycle returns the word supplied by the array. A read cycle is chip-enable low, output-enable low and write-enable high. While an internal programming cycle runs, every read returns a status word instead of array data.

The status word has three parts. The most significant bit is the inverse of the same bit of the last byte written. The next bit flips once per completed read access. The remaining bits are zero. A host can poll either bit to learn when programming has ended: the top bit then shows true data, and the flipping bit holds still.

The read strobes are active-low and are sampled by the block clock. The bus output enable and the data follow the strobes in the same cycle. The flipping bit advances on the clock edge after a read window closes, which happens when chip-enable or output-enable returns high.

Top module: `wcs_status_read`

## Requirements
- R1: `dout_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1 in the same cycle; otherwise it is 0 and `dout` is all zeros.
- R2: During a read with `busy`=1, `dout[7]` equals the inverse of `last_wdata[7]`.
- R3: During a read with `busy`=0, `dout` equals `array_rdata` on all bits, including bit 7 and bit 6.
- R4: With `busy` held at 1, `dout[6]` in each read differs from its value in the previous read. The bit advances on the clock edge after `ce_n` or `oe_n` ends the read window. Its value at the start of a programming cycle is not defined.
- R5: A write cycle (`ce_n`=0, `we_n`=0) never advances the bit 6 state. A busy read taken after a read and a write shows bit 6 changed exactly once.
- R6: During a read with `busy`=1, `dout[5:0]` is zero.
- R7: During a read with `busy`=1, `dout` does not depend on `array_rdata`.
- R8: Reads taken while `busy`=0 do not advance the bit 6 state. After a pause in programming, the first busy read shows bit 6 changed only by the busy reads before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| busy | input | 1 | Internal programming cycle in progress |
| last_wdata | input | 8 | Byte taken by the most recent write |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| array_rdata | input | 8 | Data read from the storage array |
| dout | output | 8 | Read data or status word |
| dout_oe | output | 1 | Drive enable for the data bus |

## Verification
The only state in the block is the flip bit and the registered read flag. A wrong value of either shows at the ports only as bit 6 of the next busy read. The bench therefore compares pairs of busy reads around the events that must or must not advance the bit: a closed read, a write pulse, idle reads and a pause in programming. A stuck or double-stepping flip bit shows up on the first read after such an event. Errors in the selector itself show in the very cycle of a read.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  // Bit positions of the status word relative to the data width.
  function automatic int poll_idx(input int data_w);
    return data_w - 1;
  endfunction

  function automatic int tog_idx(input int data_w);
    return data_w - 2;
  endfunction
endpackage

// File: rtl/wcs_rst_sync.sv
module wcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/wcs_strobe_decode.sv
module wcs_strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic busy,
  output logic rd_active,
  output logic adv
);
  logic window;
  logic rd_q;
  logic rd_d;

  // Read window is opened by chip- and output-enable; write-enable must be high.
  always_comb begin
    window    = ~ce_n & ~oe_n;
    rd_active = window & we_n;
    rd_d      = rd_active;
    // End of a read: a read was seen last cycle and the window is now closed.
    adv       = rd_q & ~window & busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_d;
  end
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic tog_q
);
  logic tog_d;

  always_comb begin
    tog_d = tog_q;
    if (adv) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end
endmodule

// File: rtl/wcs_out_mux.sv
module wcs_out_mux #(
  parameter int DATA_W   = 8,
  parameter int POLL_IDX = 7,
  parameter int TOG_IDX  = 6
) (
  input  logic              busy,
  input  logic              rd_active,
  input  logic              last_msb,
  input  logic              tog,
  input  logic [DATA_W-1:0] arr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] sel;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_IDX) begin : g_poll
        assign status[i] = ~last_msb;
      end else if (i == TOG_IDX) begin : g_tog
        assign status[i] = tog;
      end else begin : g_rsvd
        assign status[i] = 1'b0;
      end
    end
  endgenerate

  assign sel     = busy ? status : arr;
  assign dout    = rd_active ? sel : '0;
  assign dout_oe = rd_active;
endmodule

// File: rtl/wcs_status_read.sv
module wcs_status_read #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_wdata,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  import wcs_pkg::*;

  localparam int POLL_IDX = poll_idx(DATA_W);
  localparam int TOG_IDX  = tog_idx(DATA_W);

  logic rst_n_sync;
  logic rd_active;
  logic adv;
  logic tog_q;
  logic unused_low_bits;

  assign unused_low_bits = ^last_wdata[POLL_IDX-1:0];

  wcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  wcs_strobe_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .busy      (busy),
    .rd_active (rd_active),
    .adv       (adv)
  );

  wcs_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .adv   (adv),
    .tog_q (tog_q)
  );

  wcs_out_mux #(.DATA_W(DATA_W), .POLL_IDX(POLL_IDX), .TOG_IDX(TOG_IDX)) u_mux (
    .busy      (busy),
    .rd_active (rd_active),
    .last_msb  (last_wdata[POLL_IDX]),
    .tog       (tog_q),
    .arr       (array_rdata),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );
endmodule

// File: rtl/wcs_status_read_chk.sv
module wcs_status_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [DATA_W-1:0] last_wdata,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] array_rdata,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              tog_q
);
  localparam int PI = DATA_W - 1;
  localparam int TI = DATA_W - 2;

  logic seen_q;
  logic last_b6_q;

  // Bit 6 seen at the previous busy read, cleared whenever programming stops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      last_b6_q <= 1'b0;
    end else if (!busy) begin
      seen_q    <= 1'b0;
    end else if (dout_oe) begin
      seen_q    <= 1'b1;
      last_b6_q <= dout[TI];
    end
  end

  p_bus_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (!dout_oe && dout == '0));

  p_bus_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n) |-> dout_oe);

  p_poll_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_oe) |-> (dout[PI] == !last_wdata[PI]));

  p_array_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dout_oe) |-> (dout == array_rdata));

  p_tog_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seen_q && $rose(dout_oe)) |-> (dout[TI] != last_b6_q));

  p_no_write_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && $past(!ce_n && !we_n)) |=> $stable(tog_q));

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_oe) |-> (dout[TI-1:0] == '0));

  p_idle_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_q));
endmodule

bind wcs_status_read wcs_status_read_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .last_wdata  (last_wdata),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .array_rdata (array_rdata),
  .dout        (dout),
  .dout_oe     (dout_oe),
  .tog_q       (tog_q)
);

// File: tb/wcs_status_read_tb.sv
module wcs_status_read_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       busy;
  logic [7:0] last_wdata;
  logic       ce_n, oe_n, we_n;
  logic [7:0] array_rdata;
  logic [7:0] dout;
  logic       dout_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wcs_status_read u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_wdata(last_wdata),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .array_rdata(array_rdata),
    .dout(dout), .dout_oe(dout_oe)
  );

  // {busy, last, ce_n, oe_n, we_n, arr, exp_oe, exp_dout, mask, req}
  localparam int NV = 12;
  localparam logic [40:0] VECS [NV] = '{
    {1'b0, 8'h00, 3'b001, 8'hA5, 1'b1, 8'hA5, 8'hFF, 4'd3},
    {1'b0, 8'hFF, 3'b001, 8'h3C, 1'b1, 8'h3C, 8'hFF, 4'd3},
    {1'b0, 8'h00, 3'b101, 8'h77, 1'b0, 8'h00, 8'hFF, 4'd1},
    {1'b0, 8'h00, 3'b011, 8'h77, 1'b0, 8'h00, 8'hFF, 4'd1},
    {1'b0, 8'h00, 3'b000, 8'h77, 1'b0, 8'h00, 8'hFF, 4'd1},
    {1'b1, 8'h00, 3'b001, 8'hFF, 1'b1, 8'h80, 8'hBF, 4'd2},
    {1'b1, 8'h80, 3'b001, 8'h00, 1'b1, 8'h00, 8'hBF, 4'd2},
    {1'b1, 8'h7F, 3'b001, 8'h55, 1'b1, 8'h80, 8'hBF, 4'd6},
    {1'b1, 8'hFF, 3'b001, 8'hAA, 1'b1, 8'h00, 8'hBF, 4'd7},
    {1'b1, 8'h00, 3'b101, 8'h12, 1'b0, 8'h00, 8'hFF, 4'd1},
    {1'b0, 8'h00, 3'b001, 8'h00, 1'b1, 8'h00, 8'hFF, 4'd3},
    {1'b0, 8'hFF, 3'b001, 8'hFF, 1'b1, 8'hFF, 8'hFF, 4'd3}
  };

  task automatic check(input bit ok, input string req, input logic [8:0] act,
                       input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_read(output logic [7:0] val);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 val = dout;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; last_wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  initial begin
    logic [7:0] a, b, c, v;
    rst_n = 1'b0; busy = 1'b0; last_wdata = 8'h00;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; array_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state, strobes idle
    check(dout_oe == 1'b0 && dout == 8'h00, "R1 reset", {dout_oe, dout}, 9'h000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busy        = VECS[i][40];
      last_wdata  = VECS[i][39:32];
      {ce_n, oe_n, we_n} = VECS[i][31:29];
      array_rdata = VECS[i][28:21];
      #1;
      check(dout_oe == VECS[i][20] &&
            ((dout & VECS[i][11:4]) == (VECS[i][19:12] & VECS[i][11:4])),
            $sformatf("R%0d vec%0d", VECS[i][3:0], i),
            {dout_oe, dout}, {VECS[i][20], VECS[i][19:12]});
    end
    idle();

    // R4: successive busy reads alternate bit 6
    busy = 1'b1; last_wdata = 8'h5A; array_rdata = 8'hC3;
    do_read(a); do_read(b); do_read(c);
    check(b[6] != a[6], "R4 step1", {1'b0, b}, {1'b0, a ^ 8'h40});
    check(c[6] != b[6], "R4 step2", {1'b0, c}, {1'b0, b ^ 8'h40});
    check(a[7] == 1'b1 && a[5:0] == 6'd0, "R2 R6 status", {1'b0, a}, {1'b0, 8'h80 | (a & 8'h40)});

    // R5: a write between two reads adds no step
    do_read(a);
    do_write(8'h11);
    do_read(b);
    check(b[6] != a[6], "R5 write no step", {1'b0, b}, {1'b0, a ^ 8'h40});
    check(b[7] == 1'b1, "R2 after write", {1'b0, b}, {1'b0, 8'h80 | (b & 8'h40)});

    // R7: array data changing mid read has no effect while busy
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; array_rdata = 8'h00;
    #1 v = dout;
    @(negedge clk);
    array_rdata = 8'hFF;
    #1 check(dout == v, "R7 array ignored", {1'b0, dout}, {1'b0, v});
    idle();

    // R8: idle reads do not advance; R3 true data after completion
    do_read(a);
    @(negedge clk); busy = 1'b0; last_wdata = 8'h00; array_rdata = 8'h00;
    do_read(v);
    check(v == 8'h00, "R3 true bit7", {1'b0, v}, 9'h000);
    array_rdata = 8'h40;
    do_read(v);
    check(v == 8'h40, "R3 bit6 data", {1'b0, v}, 9'h040);
    do_read(v);
    @(negedge clk); busy = 1'b1;
    do_read(b);
    check(b[6] != a[6], "R8 idle freeze", {1'b0, b}, {1'b0, a ^ 8'h40});

    // R1: a read window with we_n low does not drive the bus
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    #1 check(dout_oe == 1'b0 && dout == 8'h00, "R1 we low", {dout_oe, dout}, 9'h000);
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule